// File: doc/BRIEF.md
# Clock-Control Register Slave

This block is a two-wire serial slave that gives a system controller access to a small bank of byte-wide clock-control registers. Both wire inputs are taken in as plain logic levels and sampled on the fast system clock. The slave pulls the data line low through an open-drain enable. Every register appears at all times on a flat parallel output, so the clock-enable logic next to it can use the values directly. The registers come up with a fill value at reset, so a system that never uses the bus still gets working clocks.

Each transfer begins with the device address. The command byte that follows picks the access type. With bit 7 high, the transfer is a single-byte access to the offset held in bits 6:0. With bit 7 low, the transfer is a block access that starts at offset 0 and moves upward one byte at a time. A block write sends a count byte ahead of its data. A block read returns the bank size first and then the registers in order. A read of either kind is reached by a repeated START followed by the read address.

Top module: `clkctl_smbus_slave`

## Requirements
- R1: After reset every register holds RESET_FILL (default 0xFF), and the data line is not driven.
- R2: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), which is 7-bit address 0x69. For any other address it sends no acknowledge and ignores the rest of the transfer.
- R3: During the ninth clock of every byte it receives after its own address, the slave pulls the data line low as an acknowledge.
- R4: A command byte with bit 7 = 1 followed by one data byte writes that byte to the register whose offset is command bits 6:0. No other register changes.
- R5: A command byte of 0x00 followed by a count byte N writes the next N data bytes to offsets 0, 1, 2 and upward. Data bytes beyond N are acknowledged but not stored.
- R6: A byte command, then a repeated START and address 0xD3, returns the addressed register most significant bit first.
- R7: A block command, then a repeated START and address 0xD3, returns NUM_REGS (default 8) first and then the registers from offset 0 upward, with each byte acknowledged by the controller. The controller may end after any complete byte by not acknowledging it.
- R8: A STOP or START at any point ends the current byte. Bits already received are discarded, the slave releases the data line, and after a START the slave waits for a new address byte.
- R9: A write to an offset at or beyond NUM_REGS is acknowledged and has no effect. A read from such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the serial clock line |
| sda_i | input | 1 | Level of the serial data line |
| sda_oe_o | output | 1 | When high, the data line is pulled low |
| regs_o | output | NUM_REGS*8 | Register bank, with offset k at bits 8k+7:8k |

## Verification
Single-byte writes and reads are run from a table that covers the lowest and highest in-range offsets, a value of all zeros and offsets beyond the bank. This shows whether the offset decode reaches exactly one register and whether out-of-range reads are forced to zero. A block write with extra bytes after its count shows whether the count limits what is stored. A block read that the controller ends early checks the order of the count byte and the data bytes. A foreign address and bytes cut off by a STOP or a repeated START show that partial or unaddressed traffic never reaches the bank.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_HOLD,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [2:0] {
        KD_ADDR,
        KD_CMD,
        KD_COUNT,
        KD_DATA,
        KD_READ
    } kind_e;

    typedef struct packed {
        phase_e              phase;
        kind_e               kind;
        logic [2:0]          bitcnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   ptr;
        logic [BYTE_W-1:0]   remaining;
        logic                is_block;
        logic                cnt_pending;
        logic                ack;
    } proto_state_t;

endpackage

// File: rtl/clkctl_bus_cond.sv
module clkctl_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } cond_state_t;

    cond_state_t q, d;

    logic scl_now;
    logic sda_now;

    always_comb begin
        d          = q;
        d.scl_sync = {q.scl_sync[SYNC_STAGES-2:0], scl_i};
        d.sda_sync = {q.sda_sync[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = q.scl_sync[SYNC_STAGES-1];
        d.sda_prev = q.sda_sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_now    = q.scl_sync[SYNC_STAGES-1];
    assign sda_now    = q.sda_sync[SYNC_STAGES-1];
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~q.scl_prev;
    assign scl_fall_o = ~scl_now & q.scl_prev;
    assign start_o    = scl_now & q.scl_prev & q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & q.scl_prev & ~q.sda_prev & sda_now;

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
    parameter int          NUM_REGS   = 8,
    parameter logic [7:0]  RESET_FILL = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [7:0]            wr_addr_i,
    input  logic [7:0]            wr_data_i,
    input  logic [7:0]            rd_addr_i,
    output logic [7:0]            rd_data_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    localparam int         IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    logic [7:0] regs_q [NUM_REGS];
    logic [7:0] regs_d [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en_i && (wr_addr_i == 8'(g))) begin
                regs_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= RESET_FILL;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end

        assign regs_o[g*8 +: 8] = regs_q[g];
    end

    always_comb begin
        if ({1'b0, rd_addr_i} < LIMIT) begin
            rd_data_o = regs_q[rd_addr_i[IDX_W-1:0]];
        end else begin
            rd_data_o = 8'h00;
        end
    end

    // R9
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ({1'b0, wr_addr_i} >= LIMIT)) |=> $stable(regs_o));

    // R4
    no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/clkctl_proto.sv
module clkctl_proto
    import clkctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [7:0] rd_data_i,
    output logic [7:0] rd_addr_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       sda_oe_o
);

    localparam logic [7:0] BANK_SIZE = 8'(NUM_REGS);

    proto_state_t q, d;
    logic [7:0]   rx_byte;
    logic [7:0]   tx_byte;

    assign rx_byte   = {q.shreg[6:0], sda_i};
    assign tx_byte   = q.cnt_pending ? BANK_SIZE : rd_data_i;
    assign rd_addr_o = q.ptr;

    always_comb begin
        d         = q;
        wr_en_o   = 1'b0;
        wr_addr_o = q.ptr;
        wr_data_o = rx_byte;

        if (stop_i) begin
            d.phase = PH_IDLE;
        end else if (start_i) begin
            d.phase  = PH_RX;
            d.kind   = KD_ADDR;
            d.bitcnt = 3'd0;
        end else begin
            unique case (q.phase)
                PH_RX: begin
                    if (scl_rise_i) begin
                        d.shreg  = rx_byte;
                        d.bitcnt = q.bitcnt + 3'd1;
                        if (q.bitcnt == 3'd7) begin
                            d.phase = PH_HOLD;
                            d.ack   = 1'b1;
                            unique case (q.kind)
                                KD_ADDR: begin
                                    if (rx_byte[7:1] == DEV_ADDR) begin
                                        if (rx_byte[0]) begin
                                            d.kind        = KD_READ;
                                            d.cnt_pending = q.is_block;
                                            if (q.is_block) begin
                                                d.ptr = 8'd0;
                                            end
                                        end else begin
                                            d.kind = KD_CMD;
                                        end
                                    end else begin
                                        d.ack = 1'b0;
                                    end
                                end
                                KD_CMD: begin
                                    if (rx_byte[7]) begin
                                        d.ptr       = {1'b0, rx_byte[6:0]};
                                        d.remaining = 8'd1;
                                        d.is_block  = 1'b0;
                                        d.kind      = KD_DATA;
                                    end else begin
                                        d.ptr      = 8'd0;
                                        d.is_block = 1'b1;
                                        d.kind     = KD_COUNT;
                                    end
                                end
                                KD_COUNT: begin
                                    d.remaining = rx_byte;
                                    d.kind      = KD_DATA;
                                end
                                KD_DATA: begin
                                    if (q.remaining != 8'd0) begin
                                        wr_en_o     = 1'b1;
                                        d.remaining = q.remaining - 8'd1;
                                        d.ptr       = q.ptr + 8'd1;
                                    end
                                end
                                default: d.ack = 1'b0;
                            endcase
                        end
                    end
                end
                PH_HOLD: begin
                    if (scl_fall_i) begin
                        d.phase = q.ack ? PH_ACK : PH_IDLE;
                    end
                end
                PH_ACK: begin
                    if (scl_fall_i) begin
                        d.bitcnt = 3'd0;
                        if (q.kind == KD_READ) begin
                            d.phase = PH_TX;
                            d.shreg = tx_byte;
                            if (q.cnt_pending) begin
                                d.cnt_pending = 1'b0;
                            end else begin
                                d.ptr = q.ptr + 8'd1;
                            end
                        end else begin
                            d.phase = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall_i) begin
                        d.shreg  = {q.shreg[6:0], 1'b0};
                        d.bitcnt = q.bitcnt + 3'd1;
                        if (q.bitcnt == 3'd7) begin
                            d.phase = PH_MACK;
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise_i && sda_i) begin
                        d.phase = PH_IDLE;
                    end else if (scl_fall_i) begin
                        d.phase  = PH_TX;
                        d.bitcnt = 3'd0;
                        d.shreg  = tx_byte;
                        if (q.cnt_pending) begin
                            d.cnt_pending = 1'b0;
                        end else begin
                            d.ptr = q.ptr + 8'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase       <= PH_IDLE;
            q.kind        <= KD_ADDR;
            q.bitcnt      <= 3'd0;
            q.shreg       <= 8'd0;
            q.ptr         <= 8'd0;
            q.remaining   <= 8'd0;
            q.is_block    <= 1'b0;
            q.cnt_pending <= 1'b0;
            q.ack         <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = (q.phase == PH_ACK) || ((q.phase == PH_TX) && !q.shreg[7]);

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> ((q.phase == PH_IDLE) && !sda_oe_o));

    // R8
    start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> ((q.phase == PH_RX) && (q.kind == KD_ADDR) && (q.bitcnt == 3'd0)));

    // R3
    ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase == PH_ACK) && !scl_fall_i && !start_i && !stop_i) |=> sda_oe_o);

endmodule

// File: rtl/clkctl_smbus_slave.sv
module clkctl_smbus_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 8,
    parameter logic [7:0] RESET_FILL  = 8'hFF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       bus_start;
    logic       bus_stop;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    clkctl_bus_cond #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    clkctl_proto #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS)
    ) u_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .sda_oe_o   (sda_oe_o)
    );

    clkctl_regbank #(
        .NUM_REGS   (NUM_REGS),
        .RESET_FILL (RESET_FILL)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

endmodule

// File: tb/clkctl_smbus_slave_tb.sv
`timescale 1ns/1ps
module clkctl_smbus_slave_tb;

    localparam int NREG = 8;
    localparam int NVEC = 10;

    // {op(0=write,1=read), offset, write data, expected read}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00_02_3C_00,
        32'h01_02_00_3C,
        32'h00_07_A5_00,
        32'h01_07_00_A5,
        32'h01_00_00_FF,
        32'h00_00_5A_00,
        32'h01_00_00_5A,
        32'h00_40_55_00,
        32'h01_40_00_00,
        32'h01_7F_00_00
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_line;
    logic              sda_oe;
    logic [NREG*8-1:0] regs;
    logic [7:0]        model [NREG];
    int                checks = 0;
    int                errors = 0;
    bit                done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    clkctl_smbus_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int k = 0; k < NREG; k++) f[k*8 +: 8] = model[k];
        return f;
    endfunction

    task automatic wq();
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ackbit);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ackbit);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(mack);
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] val);
        logic a;
        bus_start();
        put_byte(8'hD2, a);          check(a == 1'b0, "R2 addr ack", 64'(a), 64'h0);
        put_byte({1'b1, off}, a);    check(a == 1'b0, "R3 cmd ack", 64'(a), 64'h0);
        put_byte(val, a);            check(a == 1'b0, "R3 data ack", 64'(a), 64'h0);
        bus_stop();
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] v);
        logic a;
        bus_start();
        put_byte(8'hD2, a);
        put_byte({1'b1, off}, a);
        bus_start();
        put_byte(8'hD3, a);          check(a == 1'b0, "R6 read addr ack", 64'(a), 64'h0);
        get_byte(1'b1, v);
        bus_stop();
    endtask

    initial begin
        logic       a;
        logic [7:0] v;
        for (int k = 0; k < NREG; k++) model[k] = 8'hFF;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        wq();

        // R1 reset state
        check(regs == model_flat(), "R1 reset regs", 64'(regs), 64'(model_flat()));
        check(sda_oe == 1'b0, "R1 line released", 64'(sda_oe), 64'h0);

        // Table of single-byte accesses (R4, R6, R9)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][24] == 1'b0) begin
                byte_write(VEC[i][22:16], VEC[i][15:8]);
                if (VEC[i][23:16] < 8'(NREG)) model[VEC[i][18:16]] = VEC[i][15:8];
                check(regs == model_flat(), (VEC[i][23:16] < 8'(NREG)) ? "R4 byte write" : "R9 oob write",
                      64'(regs), 64'(model_flat()));
            end else begin
                byte_read(VEC[i][22:16], v);
                check(v == VEC[i][7:0], (VEC[i][23:16] < 8'(NREG)) ? "R6 byte read" : "R9 oob read",
                      64'(v), 64'(VEC[i][7:0]));
            end
        end

        // R2 foreign address: no ack, nothing stored
        bus_start();
        put_byte(8'hD4, a);          check(a == 1'b1, "R2 foreign addr nack", 64'(a), 64'h1);
        put_byte(8'h81, a);
        put_byte(8'h13, a);
        bus_stop();
        check(regs == model_flat(), "R2 foreign ignored", 64'(regs), 64'(model_flat()));

        // R5 block write with one surplus byte
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h00, a);          check(a == 1'b0, "R5 block cmd ack", 64'(a), 64'h0);
        put_byte(8'h03, a);          check(a == 1'b0, "R5 count ack", 64'(a), 64'h0);
        put_byte(8'h11, a);
        put_byte(8'h22, a);
        put_byte(8'h33, a);
        put_byte(8'h44, a);          check(a == 1'b0, "R5 surplus ack", 64'(a), 64'h0);
        bus_stop();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        check(regs == model_flat(), "R5 block write", 64'(regs), 64'(model_flat()));

        // R7 block read, ended after three data bytes
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h00, a);
        bus_start();
        put_byte(8'hD3, a);          check(a == 1'b0, "R7 read addr ack", 64'(a), 64'h0);
        get_byte(1'b0, v);           check(v == 8'(NREG), "R7 count byte", 64'(v), 64'(NREG));
        for (int k = 0; k < 3; k++) begin
            get_byte((k == 2), v);
            check(v == model[k], "R7 block data", 64'(v), 64'(model[k]));
        end
        bus_stop();
        check(sda_oe == 1'b0, "R7 released after nack", 64'(sda_oe), 64'h0);

        // R8 partial byte cut by STOP
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h85, a);
        for (int k = 0; k < 4; k++) put_bit(1'b0);
        bus_stop();
        check(regs == model_flat(), "R8 partial stop", 64'(regs), 64'(model_flat()));
        check(sda_oe == 1'b0, "R8 idle after stop", 64'(sda_oe), 64'h0);

        // R8 partial byte cut by repeated START, then a fresh write
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h86, a);
        for (int k = 0; k < 3; k++) put_bit(1'b0);
        bus_start();
        put_byte(8'hD2, a);          check(a == 1'b0, "R8 restart addr ack", 64'(a), 64'h0);
        put_byte(8'h86, a);
        put_byte(8'h77, a);
        bus_stop();
        model[6] = 8'h77;
        check(regs == model_flat(), "R8 restart write", 64'(regs), 64'(model_flat()));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule